// File: doc/BRIEF.md
# Across-Epoch Critical Thread Duration Predictor

This block predicts how long each synchronization epoch of a multithreaded program would last if the cores ran at a different clock frequency. Software or a capture unit presents one beat per epoch boundary. An epoch boundary is any moment at which a thread goes to sleep, or at which a sleeping or freshly created thread is placed on a core. The beat carries, for each of four thread slots, an active flag and the thread's duration already scaled to the target frequency. It can also name one thread that stalled at this boundary.

The block does not just take the longest thread of each epoch. It keeps a lag register for every thread slot. The lag records how far that thread trailed the critical thread, summed over the epochs so far. Each active thread's duration is first reduced by its lag. The largest reduced value is the predicted epoch length. Work that a short critical thread leaves unfinished therefore overlaps the next epoch, and is not counted twice. The block also keeps a running total of all predicted epoch lengths.

Both edges of the block use valid/ready. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the next cycle with `out_valid` high, and it stays there, unchanged, until `out_ready` is seen high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. A downstream stall therefore stalls the input after exactly one result.

Top module: `epoch_lag_predictor`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `out_total` is 0, `in_ready` is 1 and every lag register is 0. The first epoch's length is therefore the largest active duration.
- R2: For each active thread t, the effective duration is e_t = a_t − d_t, where a_t is its input duration and d_t is its lag. When d_t > a_t, e_t saturates at 0.
- R3: The predicted epoch length `out_len` is the largest e_t over the active threads. When the mask is all zeros it is 0 and `out_crit_any` is 0.
- R4: `out_crit_idx` names the thread that gives the maximum. On a tie the lowest index wins. `out_crit_any` is 1 when at least one thread is active.
- R5: Each active thread that is not critical updates its lag to d_t + len − a_t, saturating at 2^32−1.
- R6: The critical thread's lag becomes 0.
- R7: A thread whose mask bit is 0 keeps its lag and is left out of the maximum.
- R8: When `in_stall_en` is 1, the lag of thread `in_stall_idx` becomes 0 after the update, whether or not that thread is active.
- R9: `out_total` grows by `out_len` for every accepted beat, modulo 2^TOT_W. It is visible in the same cycle as that beat's result.
- R10: A result appears the cycle after its beat is accepted. Both `out_len` and `out_total` hold steady while `out_valid` is 1 and `out_ready` is 0. `in_ready` equals (not `out_valid`) or `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Epoch beat present |
| in_ready | output | 1 | Beat can be taken this cycle |
| in_mask | input | N_THR | Active thread flags, bit t is thread t |
| in_dur | input | N_THR*DUR_W | Target-frequency durations, thread t at bits [t*DUR_W +: DUR_W] |
| in_stall_en | input | 1 | A stalled thread is named |
| in_stall_idx | input | IDX_W | Index of the stalled thread |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken |
| out_len | output | DUR_W | Predicted epoch length |
| out_crit_idx | output | IDX_W | Critical thread index |
| out_crit_any | output | 1 | At least one thread was active |
| out_total | output | TOT_W | Running predicted total |

## Verification
The hardest case to reach is saturation. It needs a lag larger than the thread's next duration. Worse, upper-bound saturation of the lag needs a thread that trails by close to 2^32 cycles in two epochs running. The stimulus builds both on purpose. First, a short thread runs beside a long one and then runs alone with a tiny duration. Second, a zero-length thread runs twice beside a full-scale thread. After each setup, a lone probe epoch shows the stored lag through `out_len`. Stalls on inactive threads and downstream back-pressure with a new beat waiting are also driven directly. A long random phase then mixes mostly small and some extreme durations.

// File: rtl/elp_pkg.sv
package elp_pkg;
  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/elp_eff.sv
module elp_eff #(
  parameter int unsigned DUR_W = 32
) (
  input  logic [DUR_W-1:0] dur,
  input  logic [DUR_W-1:0] lag,
  output logic [DUR_W-1:0] eff
);
  always_comb begin
    if (dur > lag) eff = dur - lag;
    else           eff = '0;
  end
endmodule

// File: rtl/elp_argmax.sv
module elp_argmax #(
  parameter int unsigned N     = 4,
  parameter int unsigned W     = 32,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]   act,
  input  logic [N*W-1:0] val,
  output logic [W-1:0]   best,
  output logic [IDX_W-1:0] best_idx,
  output logic           any
);
  always_comb begin
    best     = '0;
    best_idx = '0;
    any      = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (act[i] && (!any || (val[i*W +: W] > best))) begin
        best     = val[i*W +: W];
        best_idx = IDX_W'(i);
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/elp_lag_bank.sv
module elp_lag_bank #(
  parameter int unsigned N     = 4,
  parameter int unsigned W     = 32,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [N-1:0]     act,
  input  logic [N*W-1:0]   dur,
  input  logic [W-1:0]     ep_len,
  input  logic [IDX_W-1:0] crit_idx,
  input  logic             crit_any,
  input  logic             stall_en,
  input  logic [IDX_W-1:0] stall_idx,
  output logic [N*W-1:0]   lag
);
  localparam logic [W-1:0] LAG_MAX = '1;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [W+1:0] sum;
    logic [W-1:0] nxt;
    logic         is_crit;
    logic         is_stall;

    assign is_crit  = crit_any && (crit_idx == IDX_W'(g));
    assign is_stall = stall_en && (stall_idx == IDX_W'(g));

    always_comb begin
      sum = {2'b00, lag[g*W +: W]} + {2'b00, ep_len} - {2'b00, dur[g*W +: W]};
      if (sum[W+1])      nxt = '0;
      else if (sum[W])   nxt = LAG_MAX;
      else               nxt = sum[W-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        lag[g*W +: W] <= '0;
      end else if (upd) begin
        if (is_stall)                lag[g*W +: W] <= '0;
        else if (act[g] && is_crit)  lag[g*W +: W] <= '0;
        else if (act[g])             lag[g*W +: W] <= nxt;
      end
    end
  end
endmodule

// File: rtl/epoch_lag_predictor.sv
module epoch_lag_predictor #(
  parameter int unsigned N_THR = 4,
  parameter int unsigned DUR_W = 32,
  parameter int unsigned TOT_W = 48,
  localparam int unsigned IDX_W = elp_pkg::idx_width(N_THR)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [N_THR-1:0]       in_mask,
  input  logic [N_THR*DUR_W-1:0] in_dur,
  input  logic                   in_stall_en,
  input  logic [IDX_W-1:0]       in_stall_idx,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [DUR_W-1:0]       out_len,
  output logic [IDX_W-1:0]       out_crit_idx,
  output logic                   out_crit_any,
  output logic [TOT_W-1:0]       out_total
);
  logic [N_THR*DUR_W-1:0] lag_flat;
  logic [N_THR*DUR_W-1:0] eff_flat;
  logic [DUR_W-1:0]       len_c;
  logic [IDX_W-1:0]       crit_c;
  logic                   any_c;
  logic                   accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  for (genvar g = 0; g < N_THR; g++) begin : g_eff
    elp_eff #(.DUR_W(DUR_W)) u_eff (
      .dur (in_dur[g*DUR_W +: DUR_W]),
      .lag (lag_flat[g*DUR_W +: DUR_W]),
      .eff (eff_flat[g*DUR_W +: DUR_W])
    );
  end

  elp_argmax #(.N(N_THR), .W(DUR_W), .IDX_W(IDX_W)) u_max (
    .act      (in_mask),
    .val      (eff_flat),
    .best     (len_c),
    .best_idx (crit_c),
    .any      (any_c)
  );

  elp_lag_bank #(.N(N_THR), .W(DUR_W), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .upd       (accept),
    .act       (in_mask),
    .dur       (in_dur),
    .ep_len    (len_c),
    .crit_idx  (crit_c),
    .crit_any  (any_c),
    .stall_en  (in_stall_en),
    .stall_idx (in_stall_idx),
    .lag       (lag_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_len      <= '0;
      out_crit_idx <= '0;
      out_crit_any <= 1'b0;
      out_total    <= '0;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_len      <= len_c;
      out_crit_idx <= crit_c;
      out_crit_any <= any_c;
      out_total    <= out_total + TOT_W'(len_c);
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/elp_checker.sv
module elp_checker #(
  parameter int unsigned N_THR = 4,
  parameter int unsigned DUR_W = 32,
  parameter int unsigned TOT_W = 48,
  parameter int unsigned IDX_W = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   accept,
  input logic [N_THR-1:0]       in_mask,
  input logic                   in_stall_en,
  input logic [IDX_W-1:0]       in_stall_idx,
  input logic                   crit_any_c,
  input logic [IDX_W-1:0]       crit_c,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [DUR_W-1:0]       out_len,
  input logic                   out_crit_any,
  input logic [TOT_W-1:0]       out_total,
  input logic [N_THR*DUR_W-1:0] lag
);
  logic [IDX_W-1:0] crit_q;
  logic [IDX_W-1:0] stall_q;

  always_ff @(posedge clk) begin
    crit_q  <= crit_c;
    stall_q <= in_stall_idx;
  end

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_len) && $stable(out_total))); // R10
  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (rst)
    accept |=> (out_total == $past(out_total) + TOT_W'(out_len))); // R9
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (accept && in_mask == '0) |=> (out_len == '0 && !out_crit_any)); // R3
  AST_CRIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (accept && crit_any_c) |=> (lag[crit_q*DUR_W +: DUR_W] == '0)); // R6
  AST_STALL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (accept && in_stall_en) |=> (lag[stall_q*DUR_W +: DUR_W] == '0)); // R8
  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(lag)); // R7
endmodule

bind epoch_lag_predictor elp_checker #(
  .N_THR(N_THR), .DUR_W(DUR_W), .TOT_W(TOT_W), .IDX_W(IDX_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .accept       (accept),
  .in_mask      (in_mask),
  .in_stall_en  (in_stall_en),
  .in_stall_idx (in_stall_idx),
  .crit_any_c   (any_c),
  .crit_c       (crit_c),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_len      (out_len),
  .out_crit_any (out_crit_any),
  .out_total    (out_total),
  .lag          (lag_flat)
);

// File: tb/sim_epoch_lag_predictor.sv
`timescale 1ns/1ps
module sim_epoch_lag_predictor;
  localparam int N = 4;
  localparam int W = 32;
  localparam int TW = 48;
  localparam longint DMAX = 64'hFFFF_FFFF;
  localparam longint TMASK = (64'd1 << TW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N-1:0] in_mask = '0;
  logic [N*W-1:0] in_dur = '0;
  logic in_stall_en = 1'b0;
  logic [1:0] in_stall_idx = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [W-1:0] out_len;
  logic [1:0] out_crit_idx;
  logic out_crit_any;
  logic [TW-1:0] out_total;

  always #2 clk = ~clk;

  epoch_lag_predictor #(.N_THR(N), .DUR_W(W), .TOT_W(TW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mask(in_mask), .in_dur(in_dur), .in_stall_en(in_stall_en),
    .in_stall_idx(in_stall_idx), .out_valid(out_valid), .out_ready(out_ready),
    .out_len(out_len), .out_crit_idx(out_crit_idx), .out_crit_any(out_crit_any),
    .out_total(out_total)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference
  longint md [N];
  bit     e_valid;
  longint e_len, e_total;
  int     e_crit;
  bit     e_any;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) md[i] = 0;
      e_valid = 0; e_len = 0; e_total = 0; e_crit = 0; e_any = 0;
    end else begin
      bit acc;
      acc = in_valid && (!e_valid || out_ready);
      if (acc) begin
        longint e [N];
        longint best;
        int bi;
        bit any;
        best = 0; bi = 0; any = 0;
        for (int i = 0; i < N; i++) begin
          longint a;
          a = longint'(in_dur[i*W +: W]);
          e[i] = (a > md[i]) ? a - md[i] : 0;
          if (in_mask[i] && (!any || e[i] > best)) begin
            best = e[i]; bi = i; any = 1;
          end
        end
        for (int i = 0; i < N; i++) begin
          longint a, s;
          a = longint'(in_dur[i*W +: W]);
          if (in_mask[i]) begin
            if (any && i == bi) md[i] = 0;
            else begin
              s = md[i] + best - a;
              md[i] = (s > DMAX) ? DMAX : ((s < 0) ? 0 : s);
            end
          end
          if (in_stall_en && int'(in_stall_idx) == i) md[i] = 0;
        end
        e_valid = 1; e_len = best; e_crit = bi; e_any = any;
        e_total = (e_total + best) & TMASK;
      end else if (out_ready) begin
        e_valid = 0;
      end
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R10 in_ready", longint'(in_ready), longint'(!e_valid || out_ready));
      chk("R10 out_valid", longint'(out_valid), longint'(e_valid));
      chk("R9 out_total", longint'(out_total), e_total);
      if (e_valid) begin
        chk("R3 out_len", longint'(out_len), e_len);
        chk("R4 out_crit_any", longint'(out_crit_any), longint'(e_any));
        if (e_any) chk("R4 out_crit_idx", longint'(out_crit_idx), longint'(e_crit));
      end
    end
  end

  task automatic drive(input logic [N-1:0] m, input longint a0, input longint a1,
                       input longint a2, input longint a3, input bit se, input int si);
    in_mask = m;
    in_dur = {W'(a3), W'(a2), W'(a1), W'(a0)};
    in_stall_en = se;
    in_stall_idx = 2'(si);
  endtask

  task automatic epoch(input string tag, input logic [N-1:0] m, input longint a0,
                       input longint a1, input longint a2, input longint a3,
                       input bit se, input int si, input longint exp_len, input int exp_crit);
    @(negedge clk);
    drive(m, a0, a1, a2, a3, se, si);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_stall_en = 1'b0;
    chk({tag, " len"}, longint'(out_len), exp_len);
    if (exp_crit >= 0) chk({tag, " crit"}, longint'(out_crit_idx), longint'(exp_crit));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset out_valid", longint'(out_valid), 0);
    chk("R1 reset out_total", longint'(out_total), 0);
    chk("R1 reset in_ready", longint'(in_ready), 1);

    epoch("R1 first epoch", 4'b0011, 10, 30, 0, 0, 0, 0, 30, 1);
    epoch("R2 saturate eff", 4'b0001, 15, 0, 0, 0, 0, 0, 0, 0);
    epoch("R6 crit lag cleared", 4'b0011, 7, 4, 0, 0, 0, 0, 7, 0);
    epoch("R5 lag reduces", 4'b0010, 0, 10, 0, 0, 0, 0, 7, 1);
    epoch("R5 setup", 4'b0011, 5, 20, 0, 0, 0, 0, 20, 1);
    epoch("R7 other runs", 4'b0010, 0, 9, 0, 0, 0, 0, 9, 1);
    epoch("R7 lag kept", 4'b0001, 25, 0, 0, 0, 0, 0, 10, 0);
    epoch("R8 setup", 4'b0011, 5, 20, 0, 0, 0, 0, 20, 1);
    epoch("R3 empty mask", 4'b0000, 0, 0, 0, 0, 1, 0, 0, -1);
    chk("R3 empty crit_any", longint'(out_crit_any), 0);
    epoch("R8 stall cleared", 4'b0001, 25, 0, 0, 0, 0, 0, 25, 0);
    epoch("R4 tie all", 4'b1111, 50, 50, 50, 50, 0, 0, 50, 0);
    epoch("R4 tie upper", 4'b1100, 0, 0, 40, 40, 0, 0, 40, 2);
    epoch("R5 big lag", 4'b0011, 0, DMAX, 0, 0, 0, 0, DMAX, 1);
    epoch("R5 lag ceiling", 4'b0011, 0, DMAX, 0, 0, 0, 0, DMAX, 1);
    epoch("R5 lag saturated", 4'b0001, DMAX, 0, 0, 0, 0, 0, 0, 0);
    epoch("R8 clear t0", 4'b0000, 0, 0, 0, 0, 1, 0, 0, -1);

    // back-pressure: result held, input stalled
    @(negedge clk);
    out_ready = 1'b0;
    drive(4'b0100, 0, 0, 77, 0, 0, 0);
    in_valid = 1'b1;
    @(negedge clk);
    drive(4'b1000, 0, 0, 0, 99, 0, 0);
    chk("R10 first result", longint'(out_len), 77);
    @(negedge clk);
    chk("R10 held in_ready", longint'(in_ready), 0);
    chk("R10 held len", longint'(out_len), 77);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 next result", longint'(out_len), 99);
    @(negedge clk);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      in_valid = ($urandom_range(0, 3) != 0);
      out_ready = ($urandom_range(0, 3) != 0);
      in_mask = 4'($urandom_range(0, 15));
      for (int t = 0; t < N; t++) begin
        if ($urandom_range(0, 19) == 0) in_dur[t*W +: W] = $urandom();
        else in_dur[t*W +: W] = W'($urandom_range(0, 1000));
      end
      in_stall_en = ($urandom_range(0, 4) == 0);
      in_stall_idx = 2'($urandom_range(0, 3));
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule